// File: doc/BRIEF.md
# Page parity ECC engine

This block builds one error-correcting code over a whole flash page while the page's words stream past on the flash data bus. For every address bit of the data (each bit of the word address and each bit of the bit position within a word), it keeps two running parities. One covers the data bits whose address has that bit set. The other covers the data bits whose address has it clear. A write path reads the two 16-bit parity words after the last data word and stores them as four code bytes.

On a read, the four stored code bytes follow the page data on the same bus, one byte per strobe on the low data lane. The engine XORs them with its own parities and classifies the result into one of five outcomes: no error, a single data-bit error (with its location), a single-bit error inside the code bytes, an uncorrectable multiple error, or a freshly erased page. It raises a one-cycle completion pulse and holds the verdict until the next parity clear.

The bus can be 8 or 16 bits wide. A two-bit mode selects the data page size: 512, 1024, 2048 or 4096 bytes.

Top module: `page_ecc`

## Requirements
- R1: After reset or a one-cycle `clear_i`, `par_o`, `npar_o`, `loc_o`, `done_o` and all four verdict flags are zero. A strobe in the same cycle as `clear_i` is dropped, and the first strobe after it is data word 0.
- R2: A page holds (512 << `mode_i`) bytes. With `wide_i`=0 it arrives as that many byte strobes on `data_i[7:0]`. With `wide_i`=1 it arrives as half as many halfword strobes on `data_i[15:0]`. The next four strobes carry the stored code bytes on `data_i[7:0]`, in the order `par` low, `par` high, `npar` low, `npar` high.
- R3: Bit k of `par_o` (k = 0..3: bit-position bit k; k = 4..15: word-address bit k-4) is the XOR of every data bit whose address has that bit set. `npar_o` is the same over the bits whose address has it clear. Both freeze after the last data word.
- R4: When the stored code equals the computed code, all four flags stay low.
- R5: A single flipped data bit raises `data_err_o` alone. `loc_o` then reads word address in [15:4] and bit offset in [3:0].
- R6: A single flipped bit in the stored code bytes raises `code_err_o` alone.
- R7: Two flipped data bits at different addresses whose address XOR is not all ones raise `multi_err_o` alone. At most one flag is ever high.
- R8: A page of all-ones data with an all-ones code raises `erased_o` alone, with `loc_o` = 16'hFFFF.
- R9: `done_o` is high for exactly the cycle after the fourth code byte is accepted.
- R10: After completion, flags, `loc_o`, `par_o` and `npar_o` hold, and further strobes are ignored, until the next clear.
- R11: In 16-bit mode the word address counts halfwords and the bit offset spans 0..15. In 8-bit mode it counts bytes, `data_i[15:8]` is ignored, and the offset spans 0..7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous parity clear, starts a new page |
| valid_i | input | 1 | Data strobe |
| data_i | input | 16 | Data word or code byte |
| mode_i | input | 2 | Page size select, 512 << mode bytes |
| wide_i | input | 1 | 1: 16-bit bus, 0: 8-bit bus |
| par_o | output | 16 | Computed parity word |
| npar_o | output | 16 | Computed complementary parity word |
| done_o | output | 1 | Check-complete pulse |
| data_err_o | output | 1 | Correctable single data-bit error |
| code_err_o | output | 1 | Single-bit error in code bytes |
| multi_err_o | output | 1 | Uncorrectable error |
| erased_o | output | 1 | Erased page detected |
| loc_o | output | 16 | Error location {word, bit} |

## Verification
A stream counter that slips by one word would charge every later data bit to the wrong address. That error stays hidden on clean pages and on the parity bits that do not depend on the address, and shows up as a wrong `loc_o` or as a false multiple error once a bit is flipped. A wrong accumulator bit appears in `par_o` or `npar_o` right after the last data word, and the verdict turns into a code or multiple error one cycle after the fourth code byte. A stuck completion state would let extra strobes change the parity outputs or raise a second `done_o` within a few cycles.

// File: rtl/page_ecc.sv
module page_ecc #(
  parameter int WA_W  = 12,
  parameter int BIT_W = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clear_i,
  input  logic                   valid_i,
  input  logic [(1<<BIT_W)-1:0]  data_i,
  input  logic [1:0]             mode_i,
  input  logic                   wide_i,
  output logic [WA_W+BIT_W-1:0]  par_o,
  output logic [WA_W+BIT_W-1:0]  npar_o,
  output logic                   done_o,
  output logic                   data_err_o,
  output logic                   code_err_o,
  output logic                   multi_err_o,
  output logic                   erased_o,
  output logic [WA_W+BIT_W-1:0]  loc_o
);
  localparam int DW    = 1 << BIT_W;
  localparam int PW    = WA_W + BIT_W;
  localparam int CNT_W = WA_W + 2;
  localparam logic [CNT_W-1:0] NARROW_BASE = CNT_W'(1) << (WA_W - 3);
  localparam logic [CNT_W-1:0] WIDE_BASE   = CNT_W'(1) << (WA_W - 4);

  logic [CNT_W-1:0] cnt_q;
  logic [PW-1:0]    p_q, n_q;
  logic [23:0]      st_q;
  logic             fin_q;

  logic [CNT_W-1:0] page_words, off;
  logic [DW-1:0]    dm;
  logic [PW-1:0]    dp, dn, sp, sn;
  logic             wpar, in_data, in_code, last;
  logic [31:0]      stored;

  assign page_words = (wide_i ? WIDE_BASE : NARROW_BASE) << mode_i;
  assign in_data = valid_i && !clear_i && !fin_q && (cnt_q < page_words);
  assign in_code = valid_i && !clear_i && !fin_q && (cnt_q >= page_words);
  assign off     = cnt_q - page_words;
  assign last    = in_code && (off[1:0] == 2'd3);
  assign dm      = wide_i ? data_i : {{(DW/2){1'b0}}, data_i[DW/2-1:0]};
  assign wpar    = ^dm;

  always_comb begin
    dp = '0;
    dn = '0;
    for (int b = 0; b < DW; b++) begin
      for (int k = 0; k < BIT_W; k++) begin
        if (((b >> k) & 1) == 1) dp[k] = dp[k] ^ dm[b];
        else                     dn[k] = dn[k] ^ dm[b];
      end
    end
    for (int k = 0; k < WA_W; k++) begin
      if (cnt_q[k]) dp[BIT_W+k] = dp[BIT_W+k] ^ wpar;
      else          dn[BIT_W+k] = dn[BIT_W+k] ^ wpar;
    end
  end

  assign stored = {data_i[7:0], st_q};
  assign sp = p_q ^ stored[PW-1:0];
  assign sn = n_q ^ stored[2*PW-1:PW];

  logic s_zero, s_data, s_code, s_multi, s_erased;
  assign s_zero   = ~|{sp, sn};
  assign s_data   = ((sp ^ sn) == '1);
  assign s_code   = ($countones({sp, sn}) == 1);
  assign s_multi  = !s_zero && !s_data && !s_code;
  assign s_erased = s_multi && (sp == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; p_q <= '0; n_q <= '0; st_q <= '0; fin_q <= 1'b0;
      done_o <= 1'b0; data_err_o <= 1'b0; code_err_o <= 1'b0;
      multi_err_o <= 1'b0; erased_o <= 1'b0; loc_o <= '0;
    end else if (clear_i) begin
      cnt_q <= '0; p_q <= '0; n_q <= '0; st_q <= '0; fin_q <= 1'b0;
      done_o <= 1'b0; data_err_o <= 1'b0; code_err_o <= 1'b0;
      multi_err_o <= 1'b0; erased_o <= 1'b0; loc_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (in_data) begin
        p_q   <= p_q ^ dp;
        n_q   <= n_q ^ dn;
        cnt_q <= cnt_q + 1'b1;
      end
      if (in_code) begin
        cnt_q <= cnt_q + 1'b1;
        case (off[1:0])
          2'd0:    st_q[7:0]   <= data_i[7:0];
          2'd1:    st_q[15:8]  <= data_i[7:0];
          2'd2:    st_q[23:16] <= data_i[7:0];
          default: ;
        endcase
      end
      if (last) begin
        fin_q       <= 1'b1;
        done_o      <= 1'b1;
        data_err_o  <= s_data;
        code_err_o  <= s_code;
        multi_err_o <= s_multi && !s_erased;
        erased_o    <= s_erased;
        loc_o       <= sp;
      end
    end
  end

  assign par_o  = p_q;
  assign npar_o = n_q;
endmodule

// File: rtl/page_ecc_chk.sv
module page_ecc_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        clear_i,
  input logic        done_o,
  input logic        fin_q,
  input logic [3:0]  flags,
  input logic [15:0] loc_o,
  input logic [15:0] par_o,
  input logic [15:0] npar_o
);
  p_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (par_o == 16'h0 && npar_o == 16'h0 && !done_o && flags == 4'h0));

  p_flags_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(flags));

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_final_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> fin_q);

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin_q && !clear_i) |=> ($stable(flags) && $stable(loc_o)));

  p_par_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin_q && !clear_i) |=> ($stable(par_o) && $stable(npar_o)));
endmodule

bind page_ecc page_ecc_chk chk_i (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .clear_i(clear_i),
  .done_o (done_o),
  .fin_q  (fin_q),
  .flags  ({data_err_o, code_err_o, multi_err_o, erased_o}),
  .loc_o  (loc_o),
  .par_o  (par_o),
  .npar_o (npar_o)
);

// File: tb/page_ecc_tb_top.sv
`timescale 1ns/1ps
module page_ecc_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, clear = 1'b0, valid = 1'b0, wide = 1'b0;
  logic [15:0] data = '0;
  logic [1:0]  mode = '0;
  logic [15:0] par, npar, loc;
  logic done, d_err, c_err, m_err, er;

  int checks = 0, fails = 0, cycles = 0;
  logic [15:0] pg [0:4095];
  logic [15:0] exp_p, exp_n;

  always #5 clk = ~clk;

  page_ecc dut_i (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .valid_i(valid), .data_i(data),
    .mode_i(mode), .wide_i(wide), .par_o(par), .npar_o(npar), .done_o(done),
    .data_err_o(d_err), .code_err_o(c_err), .multi_err_o(m_err), .erased_o(er),
    .loc_o(loc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int nwords(input logic [1:0] m, input bit w);
    return w ? (256 << m) : (512 << m);
  endfunction

  task automatic calc(input int nw, input bit w);
    exp_p = '0; exp_n = '0;
    for (int i = 0; i < nw; i++) begin
      for (int b = 0; b < (w ? 16 : 8); b++) begin
        if (pg[i][b]) begin
          logic [15:0] a;
          a = {i[11:0], 4'(b)};
          exp_p ^= a;
          exp_n ^= ~a;
        end
      end
    end
  endtask

  task automatic fill(input int nw, input bit w);
    for (int i = 0; i < nw; i++) pg[i] = 16'($urandom) & (w ? 16'hFFFF : 16'h00FF);
  endtask

  task automatic do_clear(input bit with_strobe);
    @(negedge clk);
    clear = 1'b1; valid = with_strobe; data = 16'hA5C3;
    @(negedge clk);
    clear = 1'b0; valid = 1'b0;
  endtask

  task automatic send(input logic [15:0] v);
    @(negedge clk);
    valid = 1'b1; data = v;
  endtask

  task automatic run(input int nw, input logic [31:0] code);
    for (int i = 0; i < nw; i++) send(pg[i]);
    for (int j = 0; j < 4; j++) send({8'h5A, code[8*j +: 8]});
    @(negedge clk);
    valid = 1'b0;
    chk("R9 done after last code byte", {31'b0, done}, 32'd1);
    @(negedge clk);
    chk("R9 done single pulse", {31'b0, done}, 32'd0);
  endtask

  task automatic verdict(input string req, input logic [3:0] f);
    chk(req, {28'b0, d_err, c_err, m_err, er}, {28'b0, f});
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected<=200000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    int nw, w, b;
    logic [31:0] code;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 reset par", {par, npar}, 32'h0);
    chk("R1 reset flags", {27'b0, done, d_err, c_err, m_err, er}, 32'h0);
    rst_n = 1'b1;

    // clean page, 8-bit, 512 bytes, strobe coinciding with clear dropped
    mode = 2'd0; wide = 1'b0; nw = nwords(mode, wide);
    fill(nw, wide); calc(nw, wide); code = {exp_n, exp_p};
    do_clear(1'b1);
    run(nw, code);
    chk("R3 par word", {16'b0, par}, {16'b0, exp_p});
    chk("R3 npar word", {16'b0, npar}, {16'b0, exp_n});
    verdict("R4 clean page no flags", 4'b0000);

    // R10 extra strobes ignored
    begin
      logic [15:0] sp_par, sp_npar, sp_loc;
      logic sawdone;
      sp_par = par; sp_npar = npar; sp_loc = loc; sawdone = 1'b0;
      for (int i = 0; i < 6; i++) begin
        send(16'($urandom));
        if (done) sawdone = 1'b1;
      end
      @(negedge clk); valid = 1'b0;
      chk("R10 par held", {par, npar}, {sp_par, sp_npar});
      chk("R10 loc held", {16'b0, loc}, {16'b0, sp_loc});
      chk("R10 no second done", {31'b0, sawdone}, 32'd0);
      verdict("R10 flags held", 4'b0000);
    end

    do_clear(1'b0);
    chk("R1 clear zeroes par", {par, npar}, 32'h0);

    // R11 narrow mode ignores upper lane: garbage in [15:8]
    fill(nw, 1'b0); calc(nw, 1'b0); code = {exp_n, exp_p};
    for (int i = 0; i < nw; i++) pg[i][15:8] = 8'($urandom);
    run(nw, code);
    verdict("R11 narrow upper lane ignored", 4'b0000);

    // data errors in every mode and width
    for (int m = 0; m < 4; m++) begin
      for (int ww = 0; ww < 2; ww++) begin
        mode = 2'(m); wide = ww[0]; nw = nwords(mode, wide);
        fill(nw, wide); calc(nw, wide); code = {exp_n, exp_p};
        w = int'($urandom % nw); b = int'($urandom % (wide ? 16 : 8));
        pg[w][b] = ~pg[w][b];
        do_clear(1'b0);
        run(nw, code);
        verdict(wide ? "R5 R11 wide data error flag" : "R5 R2 data error flag", 4'b1000);
        chk(wide ? "R11 wide location" : "R5 location", {16'b0, loc}, {16'b0, w[11:0], 4'(b)});
        calc(nw, wide);
        chk("R2 R3 par after flipped page", {par, npar}, {exp_p, exp_n});
      end
    end

    // code byte error
    mode = 2'd1; wide = 1'b0; nw = nwords(mode, wide);
    fill(nw, wide); calc(nw, wide); code = {exp_n, exp_p};
    code[$urandom % 32] ^= 1'b1;
    do_clear(1'b0);
    run(nw, code);
    verdict("R6 code byte error", 4'b0100);

    // double error
    mode = 2'd0; wide = 1'b1; nw = nwords(mode, wide);
    fill(nw, wide); calc(nw, wide); code = {exp_n, exp_p};
    pg[3][2] = ~pg[3][2]; pg[100][9] = ~pg[100][9];
    do_clear(1'b0);
    run(nw, code);
    verdict("R7 multiple error", 4'b0010);

    // erased pages in both widths
    for (int ww = 0; ww < 2; ww++) begin
      mode = 2'd2; wide = ww[0]; nw = nwords(mode, wide);
      for (int i = 0; i < nw; i++) pg[i] = wide ? 16'hFFFF : 16'h00FF;
      do_clear(1'b0);
      run(nw, 32'hFFFF_FFFF);
      verdict("R8 erased page", 4'b0001);
      chk("R8 erased location", {16'b0, loc}, 32'h0000_FFFF);
    end

    // clear in mid-page restarts coverage
    mode = 2'd0; wide = 1'b0; nw = nwords(mode, wide);
    do_clear(1'b0);
    for (int i = 0; i < 40; i++) send(16'($urandom));
    fill(nw, wide); calc(nw, wide); code = {exp_n, exp_p};
    do_clear(1'b0);
    run(nw, code);
    verdict("R1 restart after mid-page clear", 4'b0000);
    chk("R1 R3 par after restart", {par, npar}, {exp_p, exp_n});

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule